// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block merges level-sensitive interrupt sources into two processor lines. One is a normal interrupt request (`irq_o`) and the other is a fast interrupt request (`fiq_o`). The sources are grouped in banks of 32. Bank n owns global sources 32n through 32n+31. Each bank has a small register window on a simple word-addressed bus:

- a read-only view of the raw source levels, called the cause;
- an enable word for the normal line;
- an enable word for the fast line;
- a spare endpoint mask word.

A source takes part in a line only while its level is high and its enable bit for that line is 1. Because the cause register follows the wires, software clears a request by servicing the device that raised it, not by writing to the block.

For each bank the block also reports the lowest-numbered source that is pending on the normal path. Software can therefore service requests in ascending order without scanning the word itself. Both lines and the per-bank lowest-index outputs are registered, so they follow the sources and enables one clock later.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: While `rst` is high, all three mask words of every bank clear to 0. On the edge after reset, `irq_o`, `fiq_o`, `pend_any_o` and `bus_rdata` are all 0.
- R2: A read of word 0 of a bank returns that bank's current source levels, with bit i being global source 32n+i. A write to word 0 changes no stored state.
- R3: Word 1 of a bank is the normal-line enable. It is fully readable and writable as a 32-bit word. Writing 0 disables every source of that bank.
- R4: `irq_o` is 1 on the clock after an edge at which some bank has a source bit and its normal-enable bit both 1, and is 0 otherwise.
- R5: Word 2 of a bank is the fast-line enable. `fiq_o` follows the OR over banks of (sources AND fast enable) with the same one-clock delay, independently of the normal enable.
- R6: Word 3 of a bank is read/write storage that has no effect on `irq_o`, `fiq_o` or the pending outputs.
- R7: For bank n, `pend_idx_o[5n+4:5n]` gives the lowest bit index set in (sources AND normal enable) and `pend_any_o[n]` flags that such a bit exists. Both are registered with the same delay as `irq_o`, and the index is 0 when nothing is pending.
- R8: `bus_addr[2:0]` selects the word within a bank and the bits above select the bank. Each bank's enables act only on that bank's 32 sources.
- R9: Reads of words 4 to 7 of a bank window return 0, and writes to them change nothing.
- R10: `bus_rdata` holds the read data on the clock after a cycle with `bus_en`=1 and `bus_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive source inputs, global numbering |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BANK_W+3 | Word address: bank index above, word select in [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| pend_idx_o | output | NUM_BANKS*5 | Lowest pending normal-path index per bank |
| pend_any_o | output | NUM_BANKS | Any normal-path source pending per bank |

## Verification
The bench sweeps every source of both banks with a single enable bit. A bank decode mistake would route one bank's enables onto the other's sources, and an off-by-one in bit numbering would report the wrong lowest index. A thermometer sweep then leaves all sources high while the enable floor rises. A finder that scanned from the wrong end would report 31 throughout. Writes aimed at the cause word and at the unused upper words are followed by read-back of all masks, which catches decode that lets such writes reach storage. Setting only the endpoint mask must leave both lines low, which catches an endpoint mask wired into either line.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_SRC = 32;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    WSEL_LEVEL = 3'd0,
    WSEL_NMASK = 3'd1,
    WSEL_FMASK = 3'd2,
    WSEL_EMASK = 3'd3
  } word_sel_e;
endpackage

// File: rtl/intc_bank_regs.sv
module intc_bank_regs
  import intc_pkg::*;
#(
  parameter int W = BANK_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     lvl,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_word,
  output logic [W-1:0]     npend,
  output logic             fhit
);
  logic [W-1:0] nmask_q, fmask_q, emask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmask_q <= '0;
      fmask_q <= '0;
      emask_q <= '0;
    end else if (wr_hit) begin
      case (sel)
        WSEL_NMASK: nmask_q <= wdata;
        WSEL_FMASK: fmask_q <= wdata;
        WSEL_EMASK: emask_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      WSEL_LEVEL: rd_word = lvl;
      WSEL_NMASK: rd_word = nmask_q;
      WSEL_FMASK: rd_word = fmask_q;
      WSEL_EMASK: rd_word = emask_q;
      default:    rd_word = '0;
    endcase
  end

  assign npend = lvl & nmask_q;
  assign fhit  = |(lvl & fmask_q);

  // R3: a normal-enable write lands in full on the next edge
  assert_nmask_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == WSEL_NMASK) |=> nmask_q == $past(wdata));

  // R2 and R9: writes to the level word or to unused words leave storage alone
  assert_level_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (sel == WSEL_LEVEL || sel[2])) |=>
      ($stable(nmask_q) && $stable(fmask_q) && $stable(emask_q)));
endmodule

// File: rtl/intc_lowest_set.sv
module intc_lowest_set #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx_q,
  output logic          any_q
);
  logic [IW-1:0] idx_n;

  always_comb begin
    idx_n = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) idx_n = IW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      any_q <= 1'b0;
    end else begin
      idx_q <= idx_n;
      any_q <= |vec;
    end
  end

  // R7: no set bit sits below the reported index
  assert_lowest_first_R7: assert property (@(posedge clk) disable iff (rst)
    (any_q && !$past(rst)) |->
      (($past(vec) & ((W'(1) << idx_q) - W'(1))) == '0));

  // R7: the flag mirrors the vector one clock later
  assert_any_track_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (any_q == $past(|vec)));
endmodule

// File: rtl/lvl_irq_aggregator.sv
module lvl_irq_aggregator
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int IW     = $clog2(BANK_SRC),
  localparam int NSRC   = NUM_BANKS * BANK_SRC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSRC-1:0]         src_i,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [BANK_W+SEL_W-1:0] bus_addr,
  input  logic [BANK_SRC-1:0]     bus_wdata,
  output logic [BANK_SRC-1:0]     bus_rdata,
  output logic                    irq_o,
  output logic                    fiq_o,
  output logic [NUM_BANKS*IW-1:0] pend_idx_o,
  output logic [NUM_BANKS-1:0]    pend_any_o
);
  logic [SEL_W-1:0]    sel;
  logic [BANK_W-1:0]   bank;
  logic [BANK_SRC-1:0] bank_rd   [NUM_BANKS];
  logic [BANK_SRC-1:0] bank_pend [NUM_BANKS];
  logic [NUM_BANKS-1:0] nhit, fhit;
  logic [BANK_SRC-1:0] rd_pick;

  assign sel  = bus_addr[SEL_W-1:0];
  assign bank = bus_addr[BANK_W+SEL_W-1:SEL_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_hit;
    assign wr_hit = bus_en && bus_we && (bank == BANK_W'(b));

    intc_bank_regs #(.W(BANK_SRC)) regs_i (
      .clk     (clk),
      .rst     (rst),
      .lvl     (src_i[b*BANK_SRC +: BANK_SRC]),
      .wr_hit  (wr_hit),
      .sel     (sel),
      .wdata   (bus_wdata),
      .rd_word (bank_rd[b]),
      .npend   (bank_pend[b]),
      .fhit    (fhit[b])
    );

    assign nhit[b] = |bank_pend[b];

    intc_lowest_set #(.W(BANK_SRC)) low_i (
      .clk   (clk),
      .rst   (rst),
      .vec   (bank_pend[b]),
      .idx_q (pend_idx_o[b*IW +: IW]),
      .any_q (pend_any_o[b])
    );
  end

  always_comb begin
    rd_pick = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BANK_W'(b)) rd_pick = bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_o <= |nhit;
      fiq_o <= |fhit;
      if (bus_en && !bus_we) bus_rdata <= rd_pick;
    end
  end

  // R1: reset drives the lines and read data low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && bus_rdata == '0));

  // R4: normal line follows any bank's pending set one clock later
  assert_irq_follow_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|pend_any_src())));

  // R5: fast line follows the per-bank fast hits one clock later
  assert_fiq_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fiq_o == $past(|fhit)));

  // R9: unused words read back as zero
  assert_unused_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && sel[2]) |=> bus_rdata == '0);

  function automatic logic [NUM_BANKS-1:0] pend_any_src();
    logic [NUM_BANKS-1:0] r;
    for (int b = 0; b < NUM_BANKS; b++) r[b] = |bank_pend[b];
    return r;
  endfunction
endmodule

// File: tb/lvl_irq_aggregator_tb_top.sv
module lvl_irq_aggregator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int AW = 4;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB*32-1:0] src_i = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;
  logic [NB*IW-1:0] pend_idx_o;
  logic [NB-1:0] pend_any_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_aggregator #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst(rst), .src_i(src_i),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o),
    .pend_idx_o(pend_idx_o), .pend_any_o(pend_any_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1;
    bus_addr = AW'((bank << 3) | word);
    bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int bank, input int word, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0;
    bus_addr = AW'((bank << 3) | word);
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int k = 0; k < 32; k++) if (v[k]) return k;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq", {31'd0, fiq_o}, 32'd0);
    chk("R1 any", {30'd0, pend_any_o}, 32'd0);
    for (int b = 0; b < NB; b++)
      for (int w = 1; w < 4; w++) begin
        rd(b, w, d); chk("R1 mask clear", d, 32'd0);
      end

    // R3 normal enable read/write, R10 read latency
    wr(0, 1, 32'hA5C3_0F1E); rd(0, 1, d); chk("R3 R10 nmask rw", d, 32'hA5C3_0F1E);
    wr(0, 1, 32'h0); rd(0, 1, d); chk("R3 nmask zero", d, 32'h0);

    // R2 level read and ignored write
    @(negedge clk); src_i = {32'h1234_8001, 32'hDEAD_BEEF};
    rd(0, 0, d); chk("R2 level bank0", d, 32'hDEAD_BEEF);
    rd(1, 0, d); chk("R2 level bank1", d, 32'h1234_8001);
    wr(0, 0, 32'h0); rd(0, 0, d); chk("R2 level write ignored", d, 32'hDEAD_BEEF);
    for (int w = 1; w < 4; w++) begin rd(0, w, d); chk("R2 masks untouched", d, 32'h0); end

    // R4 R7 R8 single-bit sweep over both banks
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); src_i = '0; src_i[b*32 + i] = 1'b1;
        wr(b, 1, 32'h1 << i);
        @(negedge clk);
        chk("R4 irq single", {31'd0, irq_o}, 32'd1);
        chk("R8 any bank", {30'd0, pend_any_o}, 32'(1 << b));
        chk("R7 idx single", 32'(pend_idx_o[b*IW +: IW]), 32'(i));
        chk("R5 fiq idle", {31'd0, fiq_o}, 32'd0);
        wr(b, 1, ~(32'h1 << i));
        @(negedge clk);
        chk("R4 irq masked", {31'd0, irq_o}, 32'd0);
        wr(b, 1, 32'h0);
      end

    // R7 thermometer on bank 1 with all sources high
    @(negedge clk); src_i = '1;
    for (int k = 0; k < 32; k++) begin
      wr(1, 1, 32'hFFFF_FFFF << k);
      @(negedge clk);
      chk("R7 lowest thermo", 32'(pend_idx_o[IW +: IW]), 32'(lowest(32'hFFFF_FFFF << k)));
      chk("R7 bank0 idle", {31'd0, pend_any_o[0]}, 32'd0);
    end
    wr(1, 1, 32'h0);
    @(negedge clk);
    chk("R7 idx none", 32'(pend_idx_o[IW +: IW]), 32'd0);

    // R6 endpoint mask is inert
    wr(0, 3, 32'hFFFF_FFFF); wr(1, 3, 32'h0F0F_0F0F);
    @(negedge clk);
    chk("R6 irq low", {31'd0, irq_o}, 32'd0);
    chk("R6 fiq low", {31'd0, fiq_o}, 32'd0);
    rd(1, 3, d); chk("R6 emask rw", d, 32'h0F0F_0F0F);

    // R5 fast path independent of normal enable
    @(negedge clk); src_i = '0; src_i[32 + 7] = 1'b1;
    wr(1, 2, 32'h80);
    @(negedge clk);
    chk("R5 fiq high", {31'd0, fiq_o}, 32'd1);
    chk("R5 irq stays low", {31'd0, irq_o}, 32'd0);
    @(negedge clk); src_i = '0;
    @(negedge clk);
    chk("R5 fiq drops with level", {31'd0, fiq_o}, 32'd0);
    rd(1, 2, d); chk("R5 fmask rw", d, 32'h80);

    // R9 unused words
    for (int w = 4; w < 8; w++) begin
      wr(1, w, 32'hFFFF_FFFF);
      rd(1, w, d); chk("R9 unused read zero", d, 32'h0);
    end
    rd(1, 1, d); chk("R9 nmask unchanged", d, 32'h0);
    rd(1, 2, d); chk("R9 fmask unchanged", d, 32'h80);
    rd(1, 3, d); chk("R9 emask unchanged", d, 32'h0F0F_0F0F);

    // R1 reset mid-run clears masks
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(1, 2, d); chk("R1 reset clears fmask", d, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule